// File: doc/BRIEF.md
# CPU Bus Address Decoder with Boot Overlay

This block sits between a 16-bit, byte-wide processor bus and the memories and register page behind it. For every bus address it raises exactly one region select and produces the byte offset inside that region. The regions are the cartridge ROM port, video RAM, external RAM, work RAM, and a 512-byte internal page at the top of the map. A second copy of work RAM appears higher in the map, and addresses in that copy reach the same work RAM bytes.

After reset, a small boot ROM covers the lowest 256 bytes for reads. Software switches this overlay off by writing a one into bit 0 of a lock register. Nothing can switch it back on short of reset. The block also filters writes to two special registers. A write that does not set the lock bit is dropped. A write to the joypad select register keeps only its two select bits. The memory arrays, the bank mapper and the peripherals are outside this block.

Top module: `memmap_decoder`

## Requirements
- R1: Region select bit positions are: bit 0 cartridge port for 0x0000–0x7FFF, bit 1 video RAM for 0x8000–0x9FFF, bit 2 external RAM for 0xA000–0xBFFF, bit 3 work RAM for 0xC000–0xDFFF. The offset is the address minus the region base.
- R2: Addresses 0xE000–0xFDFF select work RAM (bit 3) with offset equal to the address minus 0xE000.
- R3: While the lock bit is 0, a read (write strobe low) below 0x0100 selects the boot ROM (bit 5) with offset equal to the address, in place of the cartridge port.
- R4: The lock bit is 0 after reset, so the overlay is active.
- R5: A write to 0xFF50 with data bit 0 equal to 1 sets the lock bit on the next clock edge. Once set, it stays set until reset, and reads below 0x0100 select the cartridge port again.
- R6: A write to 0xFF50 with data bit 0 equal to 0 is ignored: the forwarded write strobe stays low and the lock bit keeps its value.
- R7: A write to 0xFF00 forwards the data masked to bits 5 and 4 (AND 0x30).
- R8: Writes below 0x8000 select the cartridge port (bit 0) even while the overlay is active, with the data unchanged.
- R9: Addresses 0xFE00–0xFFFF select the internal page (bit 4) with offset equal to the address minus 0xFE00.
- R10: Exactly one of the six select bits is high for every address.
- R11: Every other write forwards the strobe and the data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | 16 | CPU bus address |
| bus_wr_i | input | 1 | Write strobe (low means read) |
| bus_wdata_i | input | 8 | CPU write data |
| sel_o | output | 6 | One-hot region select: cart, vram, xram, wram, page, boot |
| off_o | output | 15 | Byte offset within the selected region |
| wr_o | output | 1 | Forwarded write strobe after filtering |
| wdata_o | output | 8 | Forwarded write data after masking |
| boot_locked_o | output | 1 | Current lock bit (1 means overlay off) |

## Verification
The hardest case to reach is the one-way behaviour of the lock. It must be shown that a clearing write changes nothing, both before and after the lock is set. It must also be shown that reset is the only way to bring the overlay back. The bench walks through that sequence: a rejected write, then a setting write, then another clearing write, then a reset. At each step it re-reads the low 256 bytes. Around that sequence, the bench runs full read sweeps over all 65536 addresses with the overlay active, and a low-page sweep with it locked. The expected select and offset for each address are computed arithmetically.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
    localparam int NUM_SEL   = 6;
    localparam int NUM_BANDS = 6;

    // Select bit positions
    localparam int SEL_CART = 0;
    localparam int SEL_VRAM = 1;
    localparam int SEL_XRAM = 2;
    localparam int SEL_WRAM = 3;
    localparam int SEL_PAGE = 4;
    localparam int SEL_BOOT = 5;

    typedef struct packed {
        logic locked;
    } lock_state_s;

    // Address bands: cart, vram, xram, wram, echo of wram, internal page
    function automatic logic [15:0] band_lo(input int b);
        case (b)
            0:       return 16'h0000;
            1:       return 16'h8000;
            2:       return 16'hA000;
            3:       return 16'hC000;
            4:       return 16'hE000;
            default: return 16'hFE00;
        endcase
    endfunction

    function automatic logic [15:0] band_hi(input int b);
        case (b)
            0:       return 16'h7FFF;
            1:       return 16'h9FFF;
            2:       return 16'hBFFF;
            3:       return 16'hDFFF;
            4:       return 16'hFDFF;
            default: return 16'hFFFF;
        endcase
    endfunction
endpackage

// File: rtl/band_match.sv
module band_match #(
    parameter int              ADDR_W = 16,
    parameter logic [ADDR_W-1:0] LO   = '0,
    parameter logic [ADDR_W-1:0] HI   = '1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    localparam logic [ADDR_W-1:0] SPAN = HI - LO;

    logic [ADDR_W-1:0] rel;

    always_comb begin
        rel   = addr_i - LO;
        hit_o = (rel <= SPAN);
    end
endmodule

// File: rtl/write_filter.sv
module write_filter #(
    parameter int              ADDR_W   = 16,
    parameter int              DATA_W   = 8,
    parameter logic [ADDR_W-1:0] LOCK_ADR = 16'hFF50,
    parameter logic [ADDR_W-1:0] JOY_ADR  = 16'hFF00,
    parameter logic [DATA_W-1:0] JOY_MASK = 8'h30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              wr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              lock_set_o
);
    logic hit_lock;
    logic hit_joy;

    always_comb begin
        hit_lock   = (addr_i == LOCK_ADR);
        hit_joy    = (addr_i == JOY_ADR);
        lock_set_o = wr_i && hit_lock && wdata_i[0];
        wr_o       = wr_i && !(hit_lock && !wdata_i[0]);
        wdata_o    = hit_joy ? (wdata_i & JOY_MASK) : wdata_i;
    end

    // R7
    joy_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == JOY_ADR) |-> ((wdata_o & ~JOY_MASK) == '0))
        else $error("joypad write not masked");

    // R6
    lock_clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == LOCK_ADR && !wdata_i[0]) |-> (!wr_o && !lock_set_o))
        else $error("clearing lock write not dropped");
endmodule

// File: rtl/boot_lock.sv
module boot_lock
    import memmap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    output logic locked_o
);
    lock_state_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i) st_d.locked = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked_o = st_q.locked;

    // R5
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.locked |=> st_q.locked)
        else $error("lock bit cleared without reset");

    // R5
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.locked) |-> $past(set_i))
        else $error("lock bit set without a setting write");
endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
    import memmap_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int BOOT_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [NUM_SEL-1:0] sel_o,
    output logic [ADDR_W-2:0] off_o,
    output logic              wr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              boot_locked_o
);
    localparam int          OFF_W    = ADDR_W - 1;
    localparam logic [ADDR_W-1:0] BOOT_LIM = ADDR_W'(BOOT_BYTES);

    logic [NUM_BANDS-1:0] band_hit;
    logic                 locked;
    logic                 lock_set;
    logic                 boot_win;
    logic [ADDR_W-1:0]    base;

    for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
        band_match #(
            .ADDR_W (ADDR_W),
            .LO     (ADDR_W'(band_lo(b))),
            .HI     (ADDR_W'(band_hi(b)))
        ) band_i (
            .addr_i (bus_addr_i),
            .hit_o  (band_hit[b])
        );
    end

    write_filter #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) wfilt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (bus_addr_i),
        .wr_i       (bus_wr_i),
        .wdata_i    (bus_wdata_i),
        .wr_o       (wr_o),
        .wdata_o    (wdata_o),
        .lock_set_o (lock_set)
    );

    boot_lock lock_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (lock_set),
        .locked_o (locked)
    );

    always_comb begin
        boot_win = !locked && !bus_wr_i && (bus_addr_i < BOOT_LIM);

        sel_o           = '0;
        sel_o[SEL_CART] = band_hit[0] && !boot_win;
        sel_o[SEL_VRAM] = band_hit[1];
        sel_o[SEL_XRAM] = band_hit[2];
        sel_o[SEL_WRAM] = band_hit[3] || band_hit[4];
        sel_o[SEL_PAGE] = band_hit[5];
        sel_o[SEL_BOOT] = boot_win;

        base = '0;
        for (int b = 1; b < NUM_BANDS; b++) begin
            if (band_hit[b]) base = ADDR_W'(band_lo(b));
        end
        off_o = OFF_W'(bus_addr_i - base);
    end

    assign boot_locked_o = locked;

    // R10
    one_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel_o) == 1)
        else $error("select not one-hot");

    // R3
    boot_only_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_o[SEL_BOOT] |-> (!boot_locked_o && bus_addr_i < BOOT_LIM))
        else $error("boot select while locked or out of window");

    // R8
    cart_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && band_hit[0]) |-> (sel_o[SEL_CART] && wr_o))
        else $error("cartridge write not forwarded");
endmodule

// File: tb/memmap_decoder_tb.sv
module memmap_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr_i = '0;
    logic        bus_wr_i = 1'b0;
    logic [7:0]  bus_wdata_i = '0;
    logic [5:0]  sel_o;
    logic [14:0] off_o;
    logic        wr_o;
    logic [7:0]  wdata_o;
    logic        boot_locked_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    memmap_decoder dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_addr_i    (bus_addr_i),
        .bus_wr_i      (bus_wr_i),
        .bus_wdata_i   (bus_wdata_i),
        .sel_o         (sel_o),
        .off_o         (off_o),
        .wr_o          (wr_o),
        .wdata_o       (wdata_o),
        .boot_locked_o (boot_locked_o)
    );

    function automatic void expect_map(input logic [15:0] a, input bit lk, input bit wr,
                                       output logic [5:0] s, output logic [14:0] o);
        int ai;
        ai = int'(a);
        if (ai < 256 && !lk && !wr) begin s = 6'b100000; o = 15'(ai); end
        else if (ai < 'h8000)       begin s = 6'b000001; o = 15'(ai); end
        else if (ai < 'hA000)       begin s = 6'b000010; o = 15'(ai - 'h8000); end
        else if (ai < 'hC000)       begin s = 6'b000100; o = 15'(ai - 'hA000); end
        else if (ai < 'hE000)       begin s = 6'b001000; o = 15'(ai - 'hC000); end
        else if (ai < 'hFE00)       begin s = 6'b001000; o = 15'(ai - 'hE000); end
        else                        begin s = 6'b010000; o = 15'(ai - 'hFE00); end
    endfunction

    function automatic string req_of(input logic [15:0] a, input bit lk);
        if (int'(a) < 256 && !lk) return "R3";
        if (int'(a) >= 'hFE00)    return "R9";
        if (int'(a) >= 'hE000)    return "R2";
        return "R1";
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Combinational map check; wr=0 so no state changes, safe off-edge.
    task automatic sweep_read(input int lo, input int hi, input bit lk);
        for (int a = lo; a <= hi; a++) begin
            logic [5:0]  es;
            logic [14:0] eo;
            bus_addr_i = 16'(a);
            #1;
            expect_map(16'(a), lk, 1'b0, es, eo);
            chk(req_of(16'(a), lk), {11'd0, sel_o, off_o}, {11'd0, es, eo});
            if ($countones(sel_o) != 1) chk("R10", 32'(sel_o), 32'h1);
            #1;
        end
    endtask

    // Drive a write at a negedge; combinational outputs sampled mid-low phase.
    task automatic put_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr_i  = a;
        bus_wdata_i = d;
        bus_wr_i    = 1'b1;
        #2;
    endtask

    task automatic end_write();
        @(posedge clk);
        #2;
        bus_wr_i = 1'b0;
        #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] edges [14];
        edges = '{16'h00FF, 16'h0100, 16'h7FFF, 16'h8000, 16'h9FFF, 16'hA000,
                  16'hBFFF, 16'hC000, 16'hDFFF, 16'hE000, 16'hFDFF, 16'hFE00,
                  16'hFFFF, 16'h0000};
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #3;
        // R4: overlay active after reset
        chk("R4", 32'(boot_locked_o), 32'h0);

        // R1 R2 R3 R9 R10: full read sweep with overlay active
        sweep_read(0, 'hFFFF, 1'b0);

        // R8 R11: writes at every boundary go to their band, data untouched
        foreach (edges[i]) begin
            logic [5:0]  es;
            logic [14:0] eo;
            put_write(edges[i], 8'hA5);
            expect_map(edges[i], 1'b0, 1'b1, es, eo);
            chk(int'(edges[i]) < 'h8000 ? "R8" : "R11", {11'd0, sel_o, off_o}, {11'd0, es, eo});
            chk("R11", {23'd0, wr_o, wdata_o}, {23'd0, 1'b1, 8'hA5});
            end_write();
        end

        // R7: joypad select masking
        put_write(16'hFF00, 8'hFF);
        chk("R7", {23'd0, wr_o, wdata_o}, {23'd0, 1'b1, 8'h30});
        end_write();
        put_write(16'hFF00, 8'hCF);
        chk("R7", 32'(wdata_o), 32'h00);
        end_write();

        // R6: clearing write ignored before lock
        put_write(16'hFF50, 8'hFE);
        chk("R6", 32'(wr_o), 32'h0);
        end_write();
        chk("R6", 32'(boot_locked_o), 32'h0);
        bus_addr_i = 16'h0050;
        #1;
        chk("R3", 32'(sel_o), 32'h20);

        // R5: setting write locks the overlay
        put_write(16'hFF50, 8'h01);
        chk("R5", 32'(boot_locked_o), 32'h0);
        chk("R11", 32'(wr_o), 32'h1);
        end_write();
        chk("R5", 32'(boot_locked_o), 32'h1);
        sweep_read(0, 'h1FF, 1'b1);

        // R6 R5: clearing write after lock changes nothing
        put_write(16'hFF50, 8'h00);
        chk("R6", 32'(wr_o), 32'h0);
        end_write();
        repeat (2) @(posedge clk);
        #2;
        chk("R5", 32'(boot_locked_o), 32'h1);
        bus_addr_i = 16'h0000;
        #1;
        chk("R5", 32'(sel_o), 32'h01);

        // R4: reset restores the overlay
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #2 rst_n = 1'b1;
        #1;
        chk("R4", 32'(boot_locked_o), 32'h0);
        bus_addr_i = 16'h00FF;
        #1;
        chk("R3", {11'd0, sel_o, off_o}, {11'd0, 6'b100000, 15'h00FF});

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule